// File: doc/BRIEF.md
# Speculative Store Forwarding Buffer

This block holds the results of stores executed while the core is running ahead of a stalled long-latency miss. Those stores must not reach the data cache or memory, yet later loads on the same speculative path should still see their data. Each store leaves its line address, byte mask, data and a bogus flag here. A later load looks the buffer up and gets back a hit indication, the forwarded bytes and a bogus flag. The bogus flag tells the core that the value depends on the outstanding miss.

The buffer holds 512 bytes as 64 direct-mapped lines of 8 bytes. Each line has a tag, a valid bit, a per-byte present mask and one bogus bit. The buffer works only while the runahead-active input is high. A clear input, pulsed when runahead ends, empties every line in one cycle. Lookups sit behind the data cache rather than beside it, so the answer is registered and appears one cycle after the request.

Addresses are line addresses (byte address divided by 8). The low 6 bits select the line and the remaining bits form the tag. Byte k of a data word is bits [8k+7:8k] and is qualified by mask bit k.

Top module: `spec_store_fwd`

## Requirements
- R1: After reset every line is empty, `ld_hit_o`, `ld_bogus_o` and `ld_data_o` are 0, and any lookup misses.
- R2: A load issued while active to a line whose tag matches and whose present bytes cover the whole request returns `ld_hit_o`=1 on the cycle after the request, with the stored bytes.
- R3: A store to a valid line with the same tag merges its masked bytes into the line; bytes outside its mask keep their old values and stay present.
- R4: A store that misses allocates the line and marks only its masked bytes present; a load hits only if every requested byte is present, and unrequested bytes of `ld_data_o` read as 0.
- R5: A store to an index held by a different tag replaces that line: new tag, present mask equal to the new mask, bogus bit equal to the new flag; the old contents no longer hit.
- R6: A store with `st_data_bogus_i`=1 sets the line's bogus bit; a load that hits such a line returns `ld_bogus_o`=1; the bit stays set through later same-tag stores with good data until the line is replaced or cleared.
- R7: A store with `st_addr_bogus_i`=1 changes no line.
- R8: While `ra_active_i`=0, stores change nothing and lookups report a miss; contents are kept for when the input returns high.
- R9: `ra_clear_i`=1 empties all lines in one cycle, overrides a store in the same cycle, and a lookup in that cycle misses.
- R10: A load and a store in the same cycle see the line as it was before the store.
- R11: `ld_bogus_o` is 1 only together with `ld_hit_o`; on a miss `ld_data_o` is 0.
- R12: A load with an all-zero mask misses, and a store with an all-zero mask changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_active_i | input | 1 | Runahead mode is active |
| ra_clear_i | input | 1 | Discard all lines (runahead exit) |
| st_valid_i | input | 1 | Store request |
| st_line_i | input | LADDR_W | Store line address |
| st_mask_i | input | LINE_BYTES | Store byte mask |
| st_data_i | input | 8*LINE_BYTES | Store data |
| st_addr_bogus_i | input | 1 | Store address depends on an outstanding miss |
| st_data_bogus_i | input | 1 | Store data depends on an outstanding miss |
| ld_valid_i | input | 1 | Load lookup request |
| ld_line_i | input | LADDR_W | Load line address |
| ld_mask_i | input | LINE_BYTES | Requested bytes |
| ld_hit_o | output | 1 | Registered hit, one cycle after the request |
| ld_data_o | output | 8*LINE_BYTES | Forwarded bytes, unrequested bytes zero |
| ld_bogus_o | output | 1 | Forwarded data is bogus |

## Verification
The assertions check these properties on every cycle:
- A clear leaves no line valid.
- An idle cycle or a dropped store leaves the valid and bogus bits unchanged.
- No more than one line changes occupancy per cycle.
- A valid line never has an empty present mask.
- The bogus output and nonzero data appear only with a hit, and every internal hit reaches the output one cycle later.

Only the bench scenarios can show that data is right:
- merged bytes;
- replacement on a tag conflict;
- the bogus bit staying set;
- reads seeing old contents in the cycle of a store;
- contents surviving an inactive stretch.

The bench checks these against its own model of the lines.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [1:0] {
    LK_NONE      = 2'd0,
    LK_MISS      = 2'd1,
    LK_HIT       = 2'd2,
    LK_HIT_BOGUS = 2'd3
  } lk_class_e;
endpackage

// File: rtl/ssf_line_array.sv
module ssf_line_array #(
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned LINE_BYTES = 8,
  parameter int unsigned TAG_W      = 23,
  localparam int unsigned DATA_W    = 8 * LINE_BYTES,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [LINE_BYTES-1:0] wr_mask_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  wr_bogus_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic                  rd_valid_o,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic [LINE_BYTES-1:0] rd_pres_o,
  output logic                  rd_bogus_o,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [NUM_LINES-1:0]  occ_o,
  output logic [NUM_LINES-1:0]  bogus_o
);

  // New present mask: keep old bytes only when the same tag is being extended.
  function automatic logic [LINE_BYTES-1:0] next_present(input logic keep,
      input logic [LINE_BYTES-1:0] old_p, input logic [LINE_BYTES-1:0] add_p);
    return keep ? (old_p | add_p) : add_p;
  endfunction

  logic [TAG_W-1:0]      line_tag  [NUM_LINES];
  logic [LINE_BYTES-1:0] line_pres [NUM_LINES];
  logic [DATA_W-1:0]     line_data [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic                  v_q;
    logic                  b_q;
    logic [TAG_W-1:0]      t_q;
    logic [LINE_BYTES-1:0] p_q;
    logic [DATA_W-1:0]     d_q;
    logic                  sel;
    logic                  same_tag;

    assign sel      = wr_en_i && !clear_i && (wr_idx_i == IDX_W'(g));
    assign same_tag = v_q && (t_q == wr_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        b_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else if (clear_i) begin
        v_q <= 1'b0;
        b_q <= 1'b0;
        p_q <= '0;
      end else if (sel) begin
        v_q <= 1'b1;
        t_q <= wr_tag_i;
        p_q <= next_present(same_tag, p_q, wr_mask_i);
        b_q <= same_tag ? (b_q | wr_bogus_i) : wr_bogus_i;
      end
    end

    always_ff @(posedge clk_i) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (sel && wr_mask_i[b]) d_q[8*b +: 8] <= wr_data_i[8*b +: 8];
      end
    end

    assign occ_o[g]     = v_q;
    assign bogus_o[g]   = b_q;
    assign line_tag[g]  = t_q;
    assign line_pres[g] = p_q;
    assign line_data[g] = d_q;

    // R12: a zero-mask store never allocates, so a valid line always owns a byte
    assert_line_has_bytes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q |-> (p_q != '0));
  end

  assign rd_valid_o = occ_o[rd_idx_i];
  assign rd_bogus_o = bogus_o[rd_idx_i];
  assign rd_tag_o   = line_tag[rd_idx_i];
  assign rd_pres_o  = line_pres[rd_idx_i];
  assign rd_data_o  = line_data[rd_idx_i];

  assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (occ_o == '0) && (bogus_o == '0));

endmodule

// File: rtl/ssf_lookup.sv
module ssf_lookup
  import ssf_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 8,
  parameter int unsigned TAG_W      = 23,
  localparam int unsigned DATA_W    = 8 * LINE_BYTES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic [LINE_BYTES-1:0] req_mask_i,
  input  logic                  ent_valid_i,
  input  logic [TAG_W-1:0]      ent_tag_i,
  input  logic [LINE_BYTES-1:0] ent_pres_i,
  input  logic                  ent_bogus_i,
  input  logic [DATA_W-1:0]     ent_data_i,
  output lk_class_e             class_o,
  output logic                  hit_o,
  output logic                  bogus_o,
  output logic [DATA_W-1:0]     data_o
);

  // Every requested byte must be present, and at least one must be requested.
  function automatic logic covers(input logic [LINE_BYTES-1:0] want,
                                  input logic [LINE_BYTES-1:0] have);
    return (want != '0) && ((want & ~have) == '0);
  endfunction

  function automatic logic [DATA_W-1:0] bit_mask(input logic [LINE_BYTES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < LINE_BYTES; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  logic tag_match;
  logic is_hit;

  assign tag_match = ent_valid_i && (ent_tag_i == req_tag_i);

  always_comb begin
    if (!req_i)                                              class_o = LK_NONE;
    else if (tag_match && covers(req_mask_i, ent_pres_i))    class_o = ent_bogus_i ? LK_HIT_BOGUS : LK_HIT;
    else                                                     class_o = LK_MISS;
  end

  assign is_hit = (class_o == LK_HIT) || (class_o == LK_HIT_BOGUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o   <= 1'b0;
      bogus_o <= 1'b0;
      data_o  <= '0;
    end else begin
      hit_o   <= is_hit;
      bogus_o <= (class_o == LK_HIT_BOGUS);
      data_o  <= is_hit ? (ent_data_i & bit_mask(req_mask_i)) : '0;
    end
  end

  assert_bogus_needs_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bogus_o |-> hit_o);
  assert_miss_data_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (data_o == '0));
  assert_no_req_no_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !hit_o);

endmodule

// File: rtl/spec_store_fwd.sv
module spec_store_fwd
  import ssf_pkg::*;
#(
  parameter int unsigned LADDR_W    = 29,
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned LINE_BYTES = 8,
  localparam int unsigned DATA_W    = 8 * LINE_BYTES,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned TAG_W     = LADDR_W - IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ra_active_i,
  input  logic                  ra_clear_i,
  input  logic                  st_valid_i,
  input  logic [LADDR_W-1:0]    st_line_i,
  input  logic [LINE_BYTES-1:0] st_mask_i,
  input  logic [DATA_W-1:0]     st_data_i,
  input  logic                  st_addr_bogus_i,
  input  logic                  st_data_bogus_i,
  input  logic                  ld_valid_i,
  input  logic [LADDR_W-1:0]    ld_line_i,
  input  logic [LINE_BYTES-1:0] ld_mask_i,
  output logic                  ld_hit_o,
  output logic [DATA_W-1:0]     ld_data_o,
  output logic                  ld_bogus_o
);

  function automatic logic [IDX_W-1:0] index_of(input logic [LADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LADDR_W-1:0] a);
    return a[LADDR_W-1:IDX_W];
  endfunction

  // Named events for the assertions
  logic st_fire;
  logic st_drop;
  logic ld_fire;

  assign st_fire = ra_active_i && !ra_clear_i && st_valid_i && !st_addr_bogus_i && (st_mask_i != '0);
  assign st_drop = st_valid_i && !st_fire;
  assign ld_fire = ra_active_i && !ra_clear_i && ld_valid_i;

  logic                  ent_valid;
  logic [TAG_W-1:0]      ent_tag;
  logic [LINE_BYTES-1:0] ent_pres;
  logic                  ent_bogus;
  logic [DATA_W-1:0]     ent_data;
  logic [NUM_LINES-1:0]  occ_vec;
  logic [NUM_LINES-1:0]  bogus_vec;
  lk_class_e             lk_class;

  ssf_line_array #(
    .NUM_LINES (NUM_LINES),
    .LINE_BYTES(LINE_BYTES),
    .TAG_W     (TAG_W)
  ) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (ra_clear_i),
    .wr_en_i   (st_fire),
    .wr_idx_i  (index_of(st_line_i)),
    .wr_tag_i  (tag_of(st_line_i)),
    .wr_mask_i (st_mask_i),
    .wr_data_i (st_data_i),
    .wr_bogus_i(st_data_bogus_i),
    .rd_idx_i  (index_of(ld_line_i)),
    .rd_valid_o(ent_valid),
    .rd_tag_o  (ent_tag),
    .rd_pres_o (ent_pres),
    .rd_bogus_o(ent_bogus),
    .rd_data_o (ent_data),
    .occ_o     (occ_vec),
    .bogus_o   (bogus_vec)
  );

  ssf_lookup #(
    .LINE_BYTES(LINE_BYTES),
    .TAG_W     (TAG_W)
  ) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (ld_fire),
    .req_tag_i  (tag_of(ld_line_i)),
    .req_mask_i (ld_mask_i),
    .ent_valid_i(ent_valid),
    .ent_tag_i  (ent_tag),
    .ent_pres_i (ent_pres),
    .ent_bogus_i(ent_bogus),
    .ent_data_i (ent_data),
    .class_o    (lk_class),
    .hit_o      (ld_hit_o),
    .bogus_o    (ld_bogus_o),
    .data_o     (ld_data_o)
  );

  assert_idle_no_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ra_active_i |=> !ld_hit_o);
  assert_idle_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ra_active_i && !ra_clear_i) |=> $stable(occ_vec) && $stable(bogus_vec));
  assert_addr_bogus_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_addr_bogus_i && !ra_clear_i) |=> $stable(occ_vec) && $stable(bogus_vec));
  assert_zero_mask_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_drop && !ra_clear_i) |=> $stable(occ_vec) && $stable(bogus_vec));
  assert_one_line_per_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ra_clear_i |=> ($countones(occ_vec ^ $past(occ_vec)) <= 1));
  assert_hit_reported_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_class == LK_HIT || lk_class == LK_HIT_BOGUS) |=> ld_hit_o);
  assert_bogus_reported_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_class == LK_HIT_BOGUS) |=> ld_bogus_o);

endmodule

// File: tb/sim_spec_store_fwd.sv
module sim_spec_store_fwd;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ra_active_i = 1'b0, ra_clear_i = 1'b0;
  logic        st_valid_i = 1'b0, st_addr_bogus_i = 1'b0, st_data_bogus_i = 1'b0;
  logic [28:0] st_line_i = '0;
  logic [7:0]  st_mask_i = '0;
  logic [63:0] st_data_i = '0;
  logic        ld_valid_i = 1'b0;
  logic [28:0] ld_line_i = '0;
  logic [7:0]  ld_mask_i = '0;
  logic        ld_hit_o, ld_bogus_o;
  logic [63:0] ld_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_store_fwd u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ra_active_i(ra_active_i), .ra_clear_i(ra_clear_i),
    .st_valid_i(st_valid_i), .st_line_i(st_line_i), .st_mask_i(st_mask_i), .st_data_i(st_data_i),
    .st_addr_bogus_i(st_addr_bogus_i), .st_data_bogus_i(st_data_bogus_i),
    .ld_valid_i(ld_valid_i), .ld_line_i(ld_line_i), .ld_mask_i(ld_mask_i),
    .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o), .ld_bogus_o(ld_bogus_o));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model of the lines
  bit          m_v [64];
  bit          m_b [64];
  logic [22:0] m_t [64];
  logic [7:0]  m_p [64];
  logic [63:0] m_d [64];

  bit          e_hit = 1'b0, e_bog = 1'b0;
  logic [63:0] e_data = '0;
  string       e_tag = "R1";

  function automatic logic [63:0] widen(input logic [7:0] m);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) if (m[k]) r[8*k +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic check_rsp();
    checks++;
    if (ld_hit_o !== e_hit || ld_bogus_o !== e_bog || ld_data_o !== e_data) begin
      failures++;
      $display("FAIL %s actual hit=%0b bogus=%0b data=%h expected hit=%0b bogus=%0b data=%h",
               e_tag, ld_hit_o, ld_bogus_o, ld_data_o, e_hit, e_bog, e_data);
    end
  endtask

  task automatic step(input string tag, input bit act, input bit clr,
                      input bit st, input bit sab, input bit sdb,
                      input logic [28:0] sl, input logic [7:0] sm, input logic [63:0] sd,
                      input bit ld, input logic [28:0] ll, input logic [7:0] lm);
    int li, si;
    bit same;
    @(negedge clk);
    check_rsp();
    ra_active_i = act; ra_clear_i = clr;
    st_valid_i = st; st_addr_bogus_i = sab; st_data_bogus_i = sdb;
    st_line_i = sl; st_mask_i = sm; st_data_i = sd;
    ld_valid_i = ld; ld_line_i = ll; ld_mask_i = lm;
    // expected response, taken from the lines before this cycle's store
    li = int'(ll % 64);
    e_hit = act && !clr && ld && (lm != 0) && m_v[li] && (m_t[li] == 23'(ll >> 6))
            && ((lm & ~m_p[li]) == 0);
    e_bog = e_hit && m_b[li];
    e_data = e_hit ? (m_d[li] & widen(lm)) : 64'h0;
    if (tag != "")            e_tag = tag;
    else if (clr)             e_tag = "R9";
    else if (!act)            e_tag = "R8";
    else if (ld && lm == 0)   e_tag = "R12";
    else if (e_bog)           e_tag = "R6";
    else if (e_hit)           e_tag = "R2";
    else                      e_tag = "R4";
    // model update
    if (clr) begin
      for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_b[i] = 0; m_p[i] = 0; end
    end else if (act && st && !sab && sm != 0) begin
      si = int'(sl % 64);
      same = m_v[si] && (m_t[si] == 23'(sl >> 6));
      m_p[si] = same ? (m_p[si] | sm) : sm;
      m_b[si] = same ? (m_b[si] | sdb) : sdb;
      m_v[si] = 1; m_t[si] = 23'(sl >> 6);
      for (int k = 0; k < 8; k++) if (sm[k]) m_d[si][8*k +: 8] = sd[8*k +: 8];
    end
  endtask

  // shorthands
  task automatic put(input string tag, input logic [28:0] a, input logic [7:0] m,
                     input logic [63:0] d, input bit dbog);
    step(tag, 1, 0, 1, 0, dbog, a, m, d, 0, '0, '0);
  endtask
  task automatic get(input string tag, input logic [28:0] a, input logic [7:0] m);
    step(tag, 1, 0, 0, 0, 0, '0, '0, '0, 1, a, m);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_b[i] = 0; m_p[i] = 0; m_t[i] = 0; m_d[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state, then a lookup into the empty buffer
    get("R1", 29'h40, 8'hFF);
    // R2: full store then load
    put("R2", 29'h201, 8'hFF, 64'h1122334455667788, 0);
    get("R2", 29'h201, 8'hFF);
    // R10: load and store to the same line in one cycle see the old line
    step("R10", 1, 0, 1, 0, 0, 29'h402, 8'hFF, 64'hAAAA5555AAAA5555, 1, 29'h402, 8'hFF);
    get("R10", 29'h402, 8'hFF);
    // R4: partial store, then over-wide and narrow loads
    put("R4", 29'h603, 8'h0F, 64'hDEADBEEFCAFEF00D, 0);
    get("R4", 29'h603, 8'hFF);
    get("R4", 29'h603, 8'h03);
    // R3: second partial store merges
    put("R3", 29'h603, 8'hF0, 64'h0102030405060708, 0);
    get("R3", 29'h603, 8'hFF);
    // R5: conflicting tag on the same index replaces the line
    put("R5", 29'h643, 8'h01, 64'h00000000000000EE, 0);
    get("R5", 29'h603, 8'h01);
    get("R5", 29'h643, 8'h01);
    get("R5", 29'h643, 8'h02);
    // R6: bogus data, sticky through a good same-tag store
    put("R6", 29'h804, 8'hFF, 64'h0, 1);
    get("R6", 29'h804, 8'hFF);
    put("R6", 29'h804, 8'h0F, 64'h1234, 0);
    get("R6", 29'h804, 8'hFF);
    // R7: store with a bogus address is dropped
    step("R7", 1, 0, 1, 1, 0, 29'hA05, 8'hFF, 64'h77, 0, '0, '0);
    get("R7", 29'hA05, 8'hFF);
    // R8: inactive store ignored, inactive lookup misses, contents kept
    step("R8", 0, 0, 1, 0, 0, 29'hC06, 8'hFF, 64'h99, 0, '0, '0);
    get("R8", 29'hC06, 8'hFF);
    step("R8", 0, 0, 0, 0, 0, '0, '0, '0, 1, 29'h201, 8'hFF);
    get("R8", 29'h201, 8'hFF);
    // R12: zero-mask store and zero-mask load
    put("R12", 29'hE07, 8'h00, 64'h55, 0);
    get("R12", 29'hE07, 8'h01);
    get("R12", 29'h201, 8'h00);
    // R9: clear overrides store, same-cycle lookup misses, all lines empty
    step("R9", 1, 1, 1, 0, 0, 29'h1008, 8'hFF, 64'h42, 1, 29'h201, 8'hFF);
    get("R9", 29'h201, 8'hFF);
    get("R9", 29'h1008, 8'hFF);
    get("R9", 29'h804, 8'hFF);
    // R11 and the rest: random traffic on a small address set
    for (int n = 0; n < 4000; n++) begin
      logic [28:0] sa, la;
      logic [7:0]  sm, lm;
      sa = 29'((($urandom % 3) << 6) | ($urandom % 4));
      la = 29'((($urandom % 3) << 6) | ($urandom % 4));
      sm = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      lm = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom % 16);
      step("", ($urandom % 10) != 0, ($urandom % 50) == 0, ($urandom % 2) == 0,
           ($urandom % 20) == 0, ($urandom % 10) == 0, sa, sm, {$urandom, $urandom},
           ($urandom % 4) != 0, la, lm);
    end
    @(negedge clk);
    check_rsp();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule